// File: doc/BRIEF.md
# Multiplexed-Address DRAM Read/Write Controller

This block pairs a small memory controller with a behavioural DRAM array model. The array holds sixteen 8-bit supercells arranged as a 4 by 4 grid. A requester presents a 4-bit supercell index together with a read or write flag. The controller splits the index into a row and a column. It sends them one after the other over a 2-bit address bus that both share: the row phase comes first, then the column phase.

During the row phase the whole selected row is copied from the array into an internal row buffer. During the column phase one byte moves between that buffer and the 8-bit data path. A read returns that byte with a one-cycle done pulse. A write patches the byte in the buffer, and the full buffer is then written back to its row before the controller goes idle.

Top module: `mux_dram_ctrl`

## Requirements
- R1: After reset, busy, done, row_strobe and col_strobe are 0, rd_data is 0, dram_addr is 0, and every supercell reads back as 0.
- R2: A request is accepted on a clock edge where req_valid is 1 and busy is 0. In the cycle right after that edge, row_strobe is 1 and dram_addr carries the row, which is req_idx[3:2].
- R3: col_strobe is 1 exactly two cycles after row_strobe, and dram_addr then carries the column, which is req_idx[1:0]. The two strobes are never 1 in the same cycle.
- R4: done is a single-cycle pulse in the fourth cycle after the accepting edge. For a read, rd_data in that cycle equals the addressed supercell, and it holds that value until the next access reaches its column phase.
- R5: A write stores req_wdata in the addressed supercell and leaves the other three supercells of the same row unchanged.
- R6: In the done cycle of a write, rd_data equals the byte just written.
- R7: busy is 1 from the cycle after acceptance through the done cycle. A request presented while busy is 1 is ignored: it has no effect on the array, the strobes or rd_data.
- R8: After every one of the 16 supercells has been written with a distinct value, each one reads back its own value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_idx | input | 4 | Supercell index: row in bits 3:2, column in bits 1:0 |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Access in progress; new requests are ignored |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte returned by the last access |
| dram_addr | output | 2 | Shared row/column address bus |
| row_strobe | output | 1 | Row phase: dram_addr holds the row |
| col_strobe | output | 1 | Column phase: dram_addr holds the column |

## Verification
A table of mixed writes and reads first places bytes in one row. It then reads the neighbours in that row and a cell in the same column of another row. Together these separate a correct whole-row writeback from one that clobbers the row, and a correct row/column split from swapped or wrongly sliced index bits. A full sweep writes distinct values to all sixteen cells and reads them back against a reference array, so any aliasing between rows or columns shows up. Strobe order and bus contents are sampled on every access. A request injected while the controller is busy then shows whether the busy lockout really discards it.

// File: rtl/dram_pkg.sv
package dram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RAS     = 3'd1,
        ST_ROWLOAD = 3'd2,
        ST_CAS     = 3'd3,
        ST_DATA    = 3'd4
    } seq_state_e;

endpackage

// File: rtl/dram_seq.sv
module dram_seq #(
    parameter int AW = 2,
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [2*AW-1:0] req_idx,
    input  logic [DW-1:0]   req_wdata,
    output logic            busy,
    output logic            done,
    output logic [AW-1:0]   bus_addr,
    output logic            row_stb,
    output logic            col_stb,
    output logic            patch_en,
    output logic            wb_stb,
    output logic [DW-1:0]   patch_data
);
    import dram_pkg::*;

    localparam int IW = 2 * AW;

    typedef struct packed {
        seq_state_e    st;
        logic [IW-1:0] idx;
        logic          wr;
        logic [DW-1:0] wdata;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st    = ST_RAS;
                    d.idx   = req_idx;
                    d.wr    = req_write;
                    d.wdata = req_wdata;
                end
            end
            ST_RAS:     d.st = ST_ROWLOAD;
            ST_ROWLOAD: d.st = ST_CAS;
            ST_CAS:     d.st = ST_DATA;
            ST_DATA:    d.st = ST_IDLE;
            default:    d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, idx: '0, wr: 1'b0, wdata: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        busy       = (q.st != ST_IDLE);
        done       = (q.st == ST_DATA);
        row_stb    = (q.st == ST_RAS);
        col_stb    = (q.st == ST_CAS);
        patch_en   = col_stb && q.wr;
        wb_stb     = done && q.wr;
        patch_data = q.wdata;
        if (row_stb)      bus_addr = q.idx[IW-1:AW];
        else if (col_stb) bus_addr = q.idx[AW-1:0];
        else              bus_addr = '0;
    end

endmodule

// File: rtl/dram_array.sv
module dram_array #(
    parameter int AW = 2,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          row_stb,
    input  logic          col_stb,
    input  logic          patch_en,
    input  logic [DW-1:0] patch_data,
    input  logic          wb_stb,
    output logic [DW-1:0] data_out
);
    localparam int NROW = 1 << AW;
    localparam int NCOL = 1 << AW;

    typedef logic [NCOL-1:0][DW-1:0] row_t;

    typedef struct packed {
        logic [NROW-1:0][NCOL-1:0][DW-1:0] cells;
        row_t                              rbuf;
        logic [AW-1:0]                     open_row;
        logic [DW-1:0]                     data;
    } core_t;

    core_t q, d;

    // Column taps of the row buffer
    logic [DW-1:0] col_tap [NCOL];
    for (genvar c = 0; c < NCOL; c++) begin : g_tap
        assign col_tap[c] = q.rbuf[c];
    end

    always_comb begin
        d = q;
        if (row_stb) begin
            d.rbuf     = q.cells[bus_addr];
            d.open_row = bus_addr;
        end
        if (col_stb) begin
            if (patch_en) begin
                d.rbuf[bus_addr] = patch_data;
                d.data           = patch_data;
            end else begin
                d.data = col_tap[bus_addr];
            end
        end
        if (wb_stb) begin
            d.cells[q.open_row] = q.rbuf;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign data_out = q.data;

endmodule

// File: rtl/mux_dram_ctrl.sv
module mux_dram_ctrl #(
    parameter int AW = 2,
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [2*AW-1:0] req_idx,
    input  logic [DW-1:0]   req_wdata,
    output logic            busy,
    output logic            done,
    output logic [DW-1:0]   rd_data,
    output logic [AW-1:0]   dram_addr,
    output logic            row_strobe,
    output logic            col_strobe
);
    logic          patch_en;
    logic          wb_stb;
    logic [DW-1:0] patch_data;

    dram_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_idx    (req_idx),
        .req_wdata  (req_wdata),
        .busy       (busy),
        .done       (done),
        .bus_addr   (dram_addr),
        .row_stb    (row_strobe),
        .col_stb    (col_strobe),
        .patch_en   (patch_en),
        .wb_stb     (wb_stb),
        .patch_data (patch_data)
    );

    dram_array #(.AW(AW), .DW(DW)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (dram_addr),
        .row_stb    (row_strobe),
        .col_stb    (col_strobe),
        .patch_en   (patch_en),
        .patch_data (patch_data),
        .wb_stb     (wb_stb),
        .data_out   (rd_data)
    );

endmodule

// File: rtl/dram_ctrl_checks.sv
module dram_ctrl_checks #(
    parameter int AW = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [2*AW-1:0] req_idx,
    input logic            busy,
    input logic            done,
    input logic [AW-1:0]   dram_addr,
    input logic            row_strobe,
    input logic            col_strobe
);
    assert_accept_to_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> row_strobe);

    assert_row_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        row_strobe |-> (dram_addr == $past(req_idx[2*AW-1:AW])));

    assert_col_after_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
        row_strobe |-> ##2 col_strobe);

    assert_col_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        col_strobe |-> (dram_addr == $past(req_idx[AW-1:0], 3)));

    assert_strobes_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(row_strobe && col_strobe));

    assert_done_after_col_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(col_strobe));

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_in_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_busy_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> !row_strobe);
endmodule

bind mux_dram_ctrl dram_ctrl_checks #(.AW(AW)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_idx    (req_idx),
    .busy       (busy),
    .done       (done),
    .dram_addr  (dram_addr),
    .row_strobe (row_strobe),
    .col_strobe (col_strobe)
);

// File: tb/test_mux_dram_ctrl.sv
module test_mux_dram_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [3:0] req_idx = '0;
    logic [7:0] req_wdata = '0;
    logic       busy, done, row_strobe, col_strobe;
    logic [7:0] rd_data;
    logic [1:0] dram_addr;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] ref_mem [16];

    always #10 clk = ~clk;

    mux_dram_ctrl i_mux_dram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_idx(req_idx), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .dram_addr(dram_addr), .row_strobe(row_strobe),
        .col_strobe(col_strobe)
    );

    // {write, idx, wdata, expected rd_data}
    localparam logic [20:0] VEC [8] = '{
        {1'b1, 4'd5, 8'hA5, 8'hA5},
        {1'b1, 4'd6, 8'h3C, 8'h3C},
        {1'b0, 4'd5, 8'h00, 8'hA5},
        {1'b0, 4'd6, 8'h00, 8'h3C},
        {1'b0, 4'd4, 8'h00, 8'h00},
        {1'b0, 4'd7, 8'h00, 8'h00},
        {1'b1, 4'd9, 8'h7E, 8'h7E},
        {1'b0, 4'd1, 8'h00, 8'h00}
    };

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One access; inputs change at negedges, outputs sampled at negedges.
    task automatic access(input logic wr, input logic [3:0] idx, input logic [7:0] wd,
                          input logic inject, output logic [7:0] got);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_idx = idx; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(row_strobe && !col_strobe, "R2 row strobe", row_strobe, 1);
        chk(dram_addr == idx[3:2], "R2 row on bus", dram_addr, idx[3:2]);
        chk(busy, "R7 busy after accept", busy, 1);
        if (inject) begin
            req_valid = 1'b1; req_write = 1'b1; req_idx = 4'd12; req_wdata = 8'h55;
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(!row_strobe && !col_strobe, "R3 gap cycle", {row_strobe, col_strobe}, 0);
        @(negedge clk);
        chk(col_strobe && !row_strobe, "R3 col strobe", col_strobe, 1);
        chk(dram_addr == idx[1:0], "R3 col on bus", dram_addr, idx[1:0]);
        chk(!done, "R4 no early done", done, 0);
        @(negedge clk);
        chk(done && busy, "R4 done pulse", done, 1);
        got = rd_data;
        @(negedge clk);
        chk(!done && !busy && !row_strobe, "R7 idle after done", {done, busy, row_strobe}, 0);
        chk(rd_data == got, "R4 rd_data held", rd_data, got);
    endtask

    initial begin : main
        logic [7:0] got;
        for (int i = 0; i < 16; i++) ref_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !row_strobe && !col_strobe, "R1 control reset",
            {busy, done, row_strobe, col_strobe}, 0);
        chk(rd_data == 8'h00 && dram_addr == 2'd0, "R1 data reset", rd_data, 0);
        rst_n = 1'b1;
        access(1'b0, 4'd10, 8'h00, 1'b0, got);
        chk(got == 8'h00, "R1 array cleared", got, 0);

        // Vector table: R4 R5 R6
        for (int v = 0; v < 8; v++) begin
            access(VEC[v][20], VEC[v][19:16], VEC[v][15:8], 1'b0, got);
            chk(got == VEC[v][7:0], VEC[v][20] ? "R6 write echo" : "R4 R5 read value",
                got, VEC[v][7:0]);
            if (VEC[v][20]) ref_mem[VEC[v][19:16]] = VEC[v][15:8];
        end

        // R8 full sweep
        for (int i = 0; i < 16; i++) begin
            logic [7:0] val;
            val = 8'((i * 29 + 11) ^ (i << 4));
            access(1'b1, 4'(i), val, 1'b0, got);
            ref_mem[i] = val;
        end
        for (int i = 15; i >= 0; i--) begin
            access(1'b0, 4'(i), 8'h00, 1'b0, got);
            chk(got == ref_mem[i], "R8 sweep readback", got, ref_mem[i]);
        end

        // R7 request during busy is ignored
        access(1'b0, 4'd3, 8'h00, 1'b1, got);
        chk(got == ref_mem[3], "R7 first access intact", got, ref_mem[3]);
        access(1'b0, 4'd12, 8'h00, 1'b0, got);
        chk(got == ref_mem[12], "R7 injected write ignored", got, ref_mem[12]);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule